// File: doc/BRIEF.md
# Register-Fed CRC-16 Calculator

This block is a small register-mapped CRC engine that software drives one byte at a time. Software first clears the engine through its control register. It then writes data words into the input register, and the low byte of each write is folded into a 16-bit CRC. The control register reports how many data writes have been accepted since the last clear, and the result register holds the current check value. The engine is used to compute frame check values for an infrared serial link. It is also used for a power-up self-test: a fixed four-byte vector must give a known count and result.

The CRC uses the CCITT polynomial processed least-significant bit first, with the reflected constant 0x8408. The state is preset to all ones, and the result register returns the ones' complement of the state. Each accepted byte is absorbed in the clock edge of its write, so back-to-back writes on every cycle are accepted. Reads are registered. A read issued in the same cycle as a write returns the value after that write.

Register map (word address on `wr_addr` / `rd_addr`): 0 = control/count, 1 = input, 2 = result, 3 = unused.

Top module: `crc16_regfile`

## Requirements
- R1: After `rst_n` is released, the count reads 0, the result register reads 0x0000, and `rd_data` is 0x0000.
- R2: A write to address 0 with bit 15 set clears the CRC state to 0xFFFF and the count to 0, and takes effect at that clock edge. The bit is not stored and always reads back as 0. A write to address 0 with bit 15 clear changes nothing.
- R3: A read of address 0 returns the accepted-write count in bits 11:0, with bits 15:12 zero.
- R4: A write to address 1 keeps only bits 11:0, which read back at address 1 with bits 15:12 zero. Bits 7:0 of that write are fed into the CRC, and the count rises by one.
- R5: The CRC is LSB-first with the constant 0x8408 and preset 0xFFFF, and address 2 returns the complemented state. After a clear, the bytes 0xCC, 0xF5, 0xF1, 0xA7 give a count of 4 and a result of 0x51DF.
- R6: The count saturates at 0xFFF. Further input writes still update the CRC but leave the count at 0xFFF.
- R7: A read issued in the same cycle as a write returns the register value as it stands after that write, both for a data write and for a clear.
- R8: `rd_data` changes only on a cycle with `rd_en`. Reads of address 3 return 0. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 16 | Registered read data, valid the cycle after `rd_en` |

## Verification
Reads and writes use separate address and strobe ports, so a read can fall in the same cycle as a byte write or a clear. The bench provokes this by raising both strobes together. In one case it writes a byte while reading the result register, and it judges the returned value against its own model of the state after that byte. In the other case it clears while reading the count, and the returned count must be 0. A second overlap happens at the counter limit: the CRC still advances on a write while the count holds at 0xFFF. The bench checks this after 4100 writes against both a held count and the modelled CRC.

// File: rtl/crc16_regfile.sv
module crc16_regfile #(
  parameter int          DATA_W = 16,
  parameter int          CNT_W  = 12,
  parameter int          IN_W   = 12,
  parameter int          ADDR_W = 2,
  parameter logic [15:0] POLY   = 16'h8408,
  parameter logic [15:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] s;
    s = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++)
      s = s[0] ? ((s >> 1) ^ POLY) : (s >> 1);
    return s;
  endfunction

  logic [15:0]      crc_q, crc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IN_W-1:0]  hold_q, hold_d;

  wire clr  = wr_en && (wr_addr == A_CTRL) && wr_data[DATA_W-1];
  wire feed = wr_en && (wr_addr == A_IN);
  wire unused_hi = &{1'b0, wr_data[DATA_W-2:IN_W]};

  assign hold_d = feed ? wr_data[IN_W-1:0] : hold_q;
  assign crc_d  = clr ? PRESET : (feed ? crc_byte(crc_q, wr_data[7:0]) : crc_q);
  assign cnt_d  = clr ? '0 : ((feed && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= PRESET;
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en) begin
      case (rd_addr)
        A_CTRL:  rd_data <= {{(DATA_W-CNT_W){1'b0}}, cnt_d};
        A_IN:    rd_data <= {{(DATA_W-IN_W){1'b0}}, hold_d};
        A_OUT:   rd_data <= ~crc_d;
        default: rd_data <= '0;
      endcase
    end
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc_q == PRESET) && (cnt_q == '0));
  assert_ctrl_hi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_CTRL) |=> (rd_data[DATA_W-1:CNT_W] == '0));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (feed && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == A_CTRL || wr_addr == A_IN)) |=> ($stable(crc_q) && $stable(cnt_q)));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/crc16_regfile_tb.sv
module crc16_regfile_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_crc;
  logic [11:0] m_cnt;

  always #4 clk = ~clk;

  crc16_regfile dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) == 1'b1) r = {1'b0, r[15:1]} ^ 16'h8408;
      else r = {1'b0, r[15:1]};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (a == 2'd0 && d[15]) begin m_crc = 16'hFFFF; m_cnt = 0; end
    if (a == 2'd1) begin
      m_crc = ref_step(m_crc, d[7:0]);
      if (m_cnt != 12'hFFF) m_cnt++;
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 rd_data after reset", rd_data, 16'h0000);
    rd(2'd0, v); check("R1 count after reset", v, 16'h0000);
    rd(2'd2, v); check("R1 result after reset", v, 16'h0000);
  endtask

  task automatic t_selftest();
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h00CC); wr(2'd1, 16'h00F5); wr(2'd1, 16'h00F1); wr(2'd1, 16'h00A7);
    rd(2'd0, v); check("R5 self-test count", v, 16'h0004);
    rd(2'd2, v); check("R5 self-test result", v, 16'h51DF);
  endtask

  task automatic t_input_mask();
    logic [15:0] v;
    wr(2'd1, 16'hABCD);
    rd(2'd1, v); check("R4 input keeps low 12 bits", v, 16'h0BCD);
    rd(2'd0, v); check("R4 count after input", v, {4'h0, m_cnt});
    rd(2'd2, v); check("R4 low byte fed", v, ~m_crc);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(2'd0, 16'h7FFF);
    rd(2'd0, v); check("R2 write without bit15 ignored (count)", v, 16'h0005);
    rd(2'd2, v); check("R2 write without bit15 ignored (crc)", v, ~m_crc);
    wr(2'd0, 16'h8000);
    rd(2'd0, v); check("R2 clear count, bit15 reads 0", v, 16'h0000);
    rd(2'd2, v); check("R2 clear crc", v, 16'h0000);
  endtask

  task automatic t_patterns();
    logic [15:0] v;
    for (int p = 0; p < 3; p++) begin
      wr(2'd0, 16'h8000);
      for (int i = 0; i < 9; i++) wr(2'd1, 16'(p * 77 + i * 31 + (i << 8)));
      rd(2'd2, v); check("R5 pattern result", v, ~m_crc);
      rd(2'd0, v); check("R3 pattern count", v, 16'd9);
    end
    wr(2'd1, 16'h0000); wr(2'd1, 16'h00FF);
    rd(2'd2, v); check("R5 zero/ones bytes", v, ~m_crc);
  endtask

  task automatic t_sat();
    logic [15:0] v;
    wr(2'd0, 16'h8000);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd1;
    for (int i = 0; i < 4100; i++) begin
      wr_data = 16'(i);
      m_crc = ref_step(m_crc, 8'(i));
      if (m_cnt != 12'hFFF) m_cnt++;
      @(negedge clk);
    end
    wr_en = 0;
    rd(2'd0, v); check("R6 count saturates", v, 16'h0FFF);
    rd(2'd2, v); check("R6 crc advances at limit", v, ~m_crc);
  endtask

  task automatic t_same_cycle();
    wr(2'd0, 16'h8000);
    wr(2'd1, 16'h0011);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd1; wr_data = 16'h0022; rd_en = 1; rd_addr = 2'd2;
    m_crc = ref_step(m_crc, 8'h22); m_cnt++;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R7 read with data write sees new crc", rd_data, ~m_crc);
    @(negedge clk);
    wr_en = 1; wr_addr = 2'd0; wr_data = 16'h8000; rd_en = 1; rd_addr = 2'd0;
    m_crc = 16'hFFFF; m_cnt = 0;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R7 read with clear sees zero count", rd_data, 16'h0000);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(2'd1, 16'h005A);
    wr(2'd2, 16'hFFFF); wr(2'd3, 16'h1234);
    rd(2'd2, v); check("R8 writes to 2/3 ignored (crc)", v, ~m_crc);
    rd(2'd0, v); check("R8 writes to 2/3 ignored (count)", v, 16'h0001);
    rd(2'd3, v); check("R8 address 3 reads 0", v, 16'h0000);
    wr(2'd1, 16'h0033);
    @(negedge clk);
    check("R8 rd_data holds without rd_en", rd_data, 16'h0000);
  endtask

  initial begin
    m_crc = 16'hFFFF; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_selftest();
    t_input_mask();
    t_clear();
    t_patterns();
    t_sat();
    t_same_cycle();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule